// File: doc/BRIEF.md
# CRC Memory Scanner with Debug Hold

The scanner walks a byte-wide memory region from address zero up to a configured last address, one byte per clock, and folds each byte into a CRC-16 (polynomial 0x1021, seed 0xFFFF, most significant bit first). The last two bytes of the region hold the checksum of the bytes before it, high byte first. The check passes when the final remainder is zero. A failing check clears the OK flag and, when the interrupt enable is set, raises a non-maskable interrupt that stays high until reset. Software reaches three registers through one write port and a combinational read port. Debugger register writes use the same port and follow the same rules.

A debugger that touches memory or a peripheral puts the scanner on hold. An ongoing check is suspended and no bytes are read, but BUSY stays set. When the debugger later touches its own register space, reads the mirrored status, or detaches, the hold is lifted and the suspended check starts again from address zero. Writes to STATUS can cancel a check or queue one. Configuration is frozen while a check is in flight.

The sequencer has four states. ST_IDLE goes to ST_SCAN on a start (ST_HELD if on hold). ST_SCAN goes to ST_CHECK after reading the last address, to ST_HELD on hold, or to ST_IDLE on cancel. ST_HELD goes to ST_SCAN with the address and CRC reloaded when the hold lifts, or to ST_IDLE on cancel. ST_CHECK records the result, then goes to ST_SCAN (or ST_HELD) in continuous mode or to ST_IDLE otherwise.

Top module: `crc_scan_dbg`

## Requirements
- R1: After reset, every register reads zero, `nmi` is 0 and `mem_rd` is 0. Register addresses: 0 = control A, 1 = control B, 2 = STATUS. Control A holds ENABLE in bit 0 and NMIEN in bit 1. Control B holds the continuous-mode flag in bit 0 and the last address in bits ADDR_W:1. STATUS holds BUSY in bit 0 and OK in bit 1.
- R2: A start comes from writing ENABLE from 0 to 1 while idle. It reads addresses 0 to the last address exactly once each, in order, with `mem_rd` never above the last address. BUSY falls last+2 clocks after the start edge.
- R3: At the end of a check, OK becomes 1 if the CRC remainder is zero, otherwise 0. A failing check raises `nmi` only when NMIEN is 1.
- R4: A `dbg_mem_acc` pulse suspends the scanner. No memory read occurs while it is held, and BUSY keeps reading 1 when a check was in flight.
- R5: A held check resumes on `dbg_int_acc` or `dbg_detach` and restarts from address 0, reading the full region again.
- R6: A `dbg_stat_rd` pulse returns the status on `dbg_status` without pausing a running check. It also lifts a hold.
- R7: Writing STATUS with BUSY=0 cancels the check, and a later hold release starts nothing.
- R8: Writing STATUS with BUSY=1 while idle queues one check with the current control B settings. Under hold, BUSY reads 1 but no read happens until the hold is lifted.
- R9: While BUSY is 1, writes to control B and to NMIEN are ignored. ENABLE stays writable.
- R10: Writing STATUS with OK=0 raises `nmi` when NMIEN is 1. Once `nmi` is high it stays high, and every later register write is ignored until reset.
- R11: Writing OK=1 makes OK read 1 while BUSY is 0. OK always reads 0 while BUSY is 1.
- R12: In continuous mode with ENABLE set, a finished check restarts at address 0 at once. Clearing ENABLE lets the current pass finish and then stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe (CPU or debugger) |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | ADDR_W+1 | Register write data |
| reg_rdata | output | ADDR_W+1 | Register read data (combinational) |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_rdata | input | 8 | Memory data, valid in the same cycle |
| dbg_mem_acc | input | 1 | Debugger accesses memory or a peripheral |
| dbg_int_acc | input | 1 | Debugger accesses its own register space |
| dbg_stat_rd | input | 1 | Debugger reads mirrored status |
| dbg_detach | input | 1 | Debugger disconnects |
| dbg_status | output | 2 | Mirrored {OK, BUSY} as seen in STATUS |
| nmi | output | 1 | Sticky non-maskable interrupt |

## Verification
The check is run over a correct region, a region with one flipped byte, and a region scanned in continuous mode. Comparing the results separates a true pass from a stuck OK flag, and a stuck NMI from one gated by NMIEN. Holds are applied in the middle of a scan and released in three ways (internal access, status read, detach). A full recount of reads from address zero after release separates a restart from a resume. Cancel and queue writes are tried under hold to show that release obeys the last STATUS write. Locked writes are read back to show which fields moved.

// File: rtl/crcs_pkg.sv
package crcs_pkg;
    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_SEED = 16'hFFFF;

    localparam logic [1:0] RA_CTRLA  = 2'd0;
    localparam logic [1:0] RA_CTRLB  = 2'd1;
    localparam logic [1:0] RA_STATUS = 2'd2;

    localparam int F_EN    = 0;
    localparam int F_NMIEN = 1;
    localparam int F_MODE  = 0;
    localparam int F_BUSY  = 0;
    localparam int F_OK    = 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_HELD,
        ST_CHECK
    } scan_state_e;

    function automatic logic [15:0] crc16_step(input logic [15:0] crc, input logic [7:0] b);
        logic [15:0] c;
        c = crc ^ {b, 8'h00};
        for (int i = 0; i < 8; i++) begin
            c = c[15] ? ((c << 1) ^ CRC_POLY) : (c << 1);
        end
        return c;
    endfunction
endpackage

// File: rtl/crcs_crc_unit.sv
module crcs_crc_unit
    import crcs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        en,
    input  logic [7:0]  data,
    output logic [15:0] crc
);
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            crc <= CRC_SEED;
        end else if (en) begin
            crc <= crc16_step(crc, data);
        end
    end
endmodule

// File: rtl/crcs_seq.sv
module crcs_seq
    import crcs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              abort,
    input  logic              hold,
    input  logic              cont,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic [15:0]       crc,
    output logic              busy,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              crc_init,
    output logic              done,
    output logic              pass
);
    scan_state_e state_q, state_d;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go) state_d = hold ? ST_HELD : ST_SCAN;
            end
            ST_SCAN: begin
                if (abort)                     state_d = ST_IDLE;
                else if (hold)                 state_d = ST_HELD;
                else if (addr_q == last_addr)  state_d = ST_CHECK;
            end
            ST_HELD: begin
                if (abort)      state_d = ST_IDLE;
                else if (!hold) state_d = ST_SCAN;
            end
            ST_CHECK: begin
                if (cont && !abort) state_d = hold ? ST_HELD : ST_SCAN;
                else                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy     = (state_q != ST_IDLE);
        mem_rd   = (state_q == ST_SCAN) && !abort && !hold;
        crc_init = (state_d == ST_SCAN) && (state_q != ST_SCAN);
        done     = (state_q == ST_CHECK);
        pass     = (crc == 16'h0000);
        mem_addr = addr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || crc_init) begin
            addr_q <= '0;
        end else if (mem_rd) begin
            addr_q <= addr_q + 1'b1;
        end
    end
endmodule

// File: rtl/crcs_regs.sv
module crcs_regs
    import crcs_pkg::*;
#(
    parameter int ADDR_W = 8,
    localparam int REG_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              busy,
    input  logic              done,
    input  logic              pass,
    output logic [REG_W-1:0]  rdata,
    output logic              go,
    output logic              abort,
    output logic              cont,
    output logic              mode,
    output logic [ADDR_W-1:0] last_addr,
    output logic [1:0]        status,
    output logic              nmi
);
    logic en_q, nmien_q, ok_q;
    logic wr_a, wr_b, wr_s;

    always_comb begin
        wr_a   = wr && !nmi && (addr == RA_CTRLA);
        wr_b   = wr && !nmi && (addr == RA_CTRLB);
        wr_s   = wr && !nmi && (addr == RA_STATUS);
        go     = !busy && ((wr_a && wdata[F_EN] && !en_q) || (wr_s && wdata[F_BUSY]));
        abort  = wr_s && !wdata[F_BUSY];
        cont   = mode && en_q;
        status = '0;
        status[F_BUSY] = busy;
        status[F_OK]   = ok_q && !busy;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            nmien_q   <= 1'b0;
            mode      <= 1'b0;
            last_addr <= '0;
            ok_q      <= 1'b0;
            nmi       <= 1'b0;
        end else begin
            if (wr_a) begin
                en_q <= wdata[F_EN];
                if (!busy) nmien_q <= wdata[F_NMIEN];
            end
            if (wr_b && !busy) begin
                mode      <= wdata[F_MODE];
                last_addr <= wdata[ADDR_W:1];
            end
            if (done)      ok_q <= pass;
            else if (wr_s) ok_q <= wdata[F_OK];
            if (nmien_q && ((done && !pass) || (wr_s && !wdata[F_OK]))) nmi <= 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            RA_CTRLA: begin
                rdata[F_EN]    = en_q;
                rdata[F_NMIEN] = nmien_q;
            end
            RA_CTRLB:  rdata = {last_addr, mode};
            RA_STATUS: rdata[1:0] = status;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/crc_scan_dbg.sv
module crc_scan_dbg
    import crcs_pkg::*;
#(
    parameter int ADDR_W = 8,
    localparam int REG_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    input  logic              dbg_mem_acc,
    input  logic              dbg_int_acc,
    input  logic              dbg_stat_rd,
    input  logic              dbg_detach,
    output logic [1:0]        dbg_status,
    output logic              nmi
);
    logic              hold_q, hold_now, release_req;
    logic              go, abort, cont, cfg_mode, busy, done, pass, crc_init;
    logic [ADDR_W-1:0] cfg_last;
    logic [15:0]       crc;
    logic [1:0]        status;

    // A memory/peripheral access arms the hold; any internal access releases it.
    always_comb begin
        release_req = dbg_int_acc || dbg_stat_rd || dbg_detach;
        hold_now    = dbg_mem_acc || hold_q;
        dbg_status  = status;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else begin
            hold_q <= dbg_mem_acc || (hold_q && !release_req);
        end
    end

    crcs_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .busy      (busy),
        .done      (done),
        .pass      (pass),
        .rdata     (reg_rdata),
        .go        (go),
        .abort     (abort),
        .cont      (cont),
        .mode      (cfg_mode),
        .last_addr (cfg_last),
        .status    (status),
        .nmi       (nmi)
    );

    crcs_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .abort     (abort),
        .hold      (hold_now),
        .cont      (cont),
        .last_addr (cfg_last),
        .crc       (crc),
        .busy      (busy),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .crc_init  (crc_init),
        .done      (done),
        .pass      (pass)
    );

    crcs_crc_unit u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (crc_init),
        .en    (mem_rd),
        .data  (mem_rdata),
        .crc   (crc)
    );
endmodule

// File: rtl/crcs_chk.sv
module crcs_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] cfg_last,
    input logic              cfg_mode,
    input logic              hold_now,
    input logic              busy,
    input logic              nmi
);
    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (mem_addr <= cfg_last)); // R2
    AST_HELD_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        hold_now |-> !mem_rd); // R4
    AST_SCAN_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd) |-> (mem_addr == '0)); // R5
    AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> ($stable(cfg_last) && $stable(cfg_mode))); // R9
    AST_NMI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(nmi) |-> nmi); // R10
    AST_NMI_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(nmi) |-> ($stable(cfg_last) && $stable(cfg_mode))); // R10
endmodule

bind crc_scan_dbg crcs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_rd   (mem_rd),
    .mem_addr (mem_addr),
    .cfg_last (cfg_last),
    .cfg_mode (cfg_mode),
    .hold_now (hold_now),
    .busy     (busy),
    .nmi      (nmi)
);

// File: tb/crc_scan_dbg_bench.sv
`timescale 1ns/1ps
module crc_scan_dbg_bench;
    localparam int AW = 8;
    localparam int RW = AW + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [RW-1:0] reg_wdata = '0;
    logic [RW-1:0] reg_rdata;
    logic          mem_rd;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_rdata;
    logic          dbg_mem_acc = 1'b0, dbg_int_acc = 1'b0, dbg_stat_rd = 1'b0, dbg_detach = 1'b0;
    logic [1:0]    dbg_status;
    logic          nmi;

    logic [7:0] mem [0:255];
    int n_chk = 0, n_fail = 0;
    int cyc = 0, total_rd = 0;
    logic [AW-1:0] first_addr = '0;
    logic prev_rd = 1'b0;
    bit done_flag = 0;

    always #5 clk = ~clk;
    assign mem_rdata = mem[mem_addr];

    crc_scan_dbg #(.ADDR_W(AW)) u_crc_scan_dbg (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .dbg_mem_acc(dbg_mem_acc),
        .dbg_int_acc(dbg_int_acc), .dbg_stat_rd(dbg_stat_rd), .dbg_detach(dbg_detach),
        .dbg_status(dbg_status), .nmi(nmi)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        prev_rd <= rst_n && mem_rd;
        if (rst_n && mem_rd) begin
            total_rd <= total_rd + 1;
            if (!prev_rd) first_addr <= mem_addr;
        end
    end

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        if (cyc == 150000 && !done_flag) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            report();
            $finish;
        end
    end

    task automatic check_eq(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input int n);
        logic [15:0] r = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            for (int b = 7; b >= 0; b--) begin
                logic fb;
                fb = r[15] ^ mem[i][b];
                r = {r[14:0], 1'b0};
                if (fb) r = r ^ 16'h1021;
            end
        end
        return r;
    endfunction

    task automatic build(input int last, input bit corrupt);
        logic [15:0] c;
        for (int i = 0; i < last - 1; i++) mem[i] = 8'((i * 7 + 3) ^ (i >> 2));
        c = ref_crc(last - 1);
        mem[last - 1] = c[15:8];
        mem[last]     = c[7:0];
        if (corrupt) mem[3] = mem[3] ^ 8'h10;
    endtask

    task automatic wr(input logic [1:0] a, input logic [RW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [RW-1:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // 0 mem access, 1 internal access, 2 status read, 3 detach
    task automatic dbg_pulse(input int kind);
        @(negedge clk);
        dbg_mem_acc = (kind == 0); dbg_int_acc = (kind == 1);
        dbg_stat_rd = (kind == 2); dbg_detach  = (kind == 3);
        @(negedge clk);
        dbg_mem_acc = 0; dbg_int_acc = 0; dbg_stat_rd = 0; dbg_detach = 0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (dbg_status[0] && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    function automatic logic [RW-1:0] ctrlb(input int last, input bit cont);
        return {8'(last), cont};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [RW-1:0] v;
        rd(2'd0, v); check_eq("R1", "ctrl A after reset", v, 0);
        rd(2'd1, v); check_eq("R1", "ctrl B after reset", v, 0);
        rd(2'd2, v); check_eq("R1", "status after reset", v, 0);
        check_eq("R1", "nmi after reset", nmi, 0);
        check_eq("R1", "mem_rd after reset", mem_rd, 0);
    endtask

    task automatic t_single_pass();
        int t0, base;
        logic [RW-1:0] v;
        build(31, 0);
        wr(2'd1, ctrlb(31, 0));
        base = total_rd;
        wr(2'd0, 9'b01);
        t0 = cyc;
        check_eq("R2", "busy after start", dbg_status[0], 1);
        wait_idle();
        check_eq("R2", "clocks to idle", cyc - t0, 33);
        check_eq("R2", "reads per check", total_rd - base, 32);
        check_eq("R2", "first address", first_addr, 0);
        rd(2'd2, v); check_eq("R3", "status after good check", v, 2);
        check_eq("R3", "nmi after pass", nmi, 0);
    endtask

    task automatic t_fail_quiet();
        logic [RW-1:0] v;
        build(31, 1);
        wr(2'd2, 9'b11);
        wait_idle();
        rd(2'd2, v); check_eq("R3", "status after bad check", v, 0);
        check_eq("R3", "nmi with NMIEN clear", nmi, 0);
        wr(2'd2, 9'b10);
        rd(2'd2, v); check_eq("R11", "OK written to 1 while idle", v, 2);
    endtask

    task automatic t_lock();
        logic [RW-1:0] v;
        build(31, 0);
        wr(2'd2, 9'b11);
        rd(2'd2, v); check_eq("R11", "OK hidden while busy", v, 1);
        wr(2'd1, ctrlb(9, 1));
        wr(2'd0, 9'b10);
        rd(2'd1, v); check_eq("R9", "ctrl B frozen while busy", v, ctrlb(31, 0));
        rd(2'd0, v); check_eq("R9", "NMIEN frozen, ENABLE taken", v, 0);
        wait_idle();
        wr(2'd1, ctrlb(9, 0));
        rd(2'd1, v); check_eq("R9", "ctrl B writable when idle", v, ctrlb(9, 0));
        wr(2'd1, ctrlb(31, 0));
    endtask

    task automatic t_hold_restart(input int rel_kind, input string req);
        int base;
        logic [RW-1:0] v;
        build(31, 0);
        wr(2'd2, 9'b11);
        repeat (4) @(negedge clk);
        dbg_pulse(0);
        base = total_rd;
        repeat (8) @(negedge clk);
        check_eq("R4", "reads during hold", total_rd - base, 0);
        check_eq("R4", "mirrored busy during hold", dbg_status[0], 1);
        rd(2'd2, v); check_eq("R4", "status busy during hold", v, 1);
        base = total_rd;
        dbg_pulse(rel_kind);
        wait_idle();
        check_eq(req, "restart address", first_addr, 0);
        check_eq(req, "full region reread", total_rd - base, 32);
        rd(2'd2, v); check_eq(req, "result after restart", v, 2);
    endtask

    task automatic t_stat_read();
        int t0, base;
        build(31, 0);
        base = total_rd;
        wr(2'd2, 9'b11);
        t0 = cyc;
        repeat (3) @(negedge clk);
        dbg_pulse(2);
        check_eq("R6", "scan runs after status read", mem_rd, 1);
        check_eq("R6", "mirrored busy", dbg_status[0], 1);
        wait_idle();
        check_eq("R6", "no delay from status read", cyc - t0, 33);
        check_eq("R6", "reads uninterrupted", total_rd - base, 32);
    endtask

    task automatic t_abort();
        int base;
        build(31, 0);
        wr(2'd2, 9'b11);
        repeat (3) @(negedge clk);
        dbg_pulse(0);
        wr(2'd2, 9'b10);
        check_eq("R7", "busy after cancel", dbg_status[0], 0);
        base = total_rd;
        dbg_pulse(3);
        repeat (40) @(negedge clk);
        check_eq("R7", "reads after release", total_rd - base, 0);
        check_eq("R7", "busy after release", dbg_status[0], 0);
    endtask

    task automatic t_queue();
        int base;
        build(31, 0);
        dbg_pulse(0);
        base = total_rd;
        wr(2'd2, 9'b11);
        check_eq("R8", "queued check shows busy", dbg_status[0], 1);
        repeat (10) @(negedge clk);
        check_eq("R8", "no reads before release", total_rd - base, 0);
        dbg_pulse(3);
        wait_idle();
        check_eq("R8", "queued check ran once", total_rd - base, 32);
        check_eq("R8", "queued check OK", dbg_status, 2);
    endtask

    task automatic t_cont();
        int base;
        logic [RW-1:0] v;
        build(15, 0);
        wr(2'd0, 9'b00);
        wr(2'd1, ctrlb(15, 1));
        base = total_rd;
        wr(2'd0, 9'b01);
        repeat (40) @(negedge clk);
        check_eq("R12", "still busy in continuous", dbg_status[0], 1);
        check_eq("R12", "two passes done", (total_rd - base) >= 32, 1);
        wr(2'd0, 9'b00);
        wait_idle();
        check_eq("R12", "whole passes only", (total_rd - base) % 16, 0);
        rd(2'd2, v); check_eq("R12", "continuous result", v, 2);
    endtask

    task automatic t_fail_nmi();
        build(31, 1);
        wr(2'd0, 9'b10);
        wr(2'd1, ctrlb(31, 0));
        wr(2'd2, 9'b11);
        wait_idle();
        check_eq("R3", "nmi on failed check", nmi, 1);
        check_eq("R3", "OK after failed check", dbg_status, 0);
    endtask

    task automatic t_ok_write_nmi();
        logic [RW-1:0] v;
        int base;
        wr(2'd0, 9'b10);
        wr(2'd1, ctrlb(7, 0));
        check_eq("R10", "nmi before OK write", nmi, 0);
        wr(2'd2, 9'b00);
        check_eq("R10", "nmi after OK=0", nmi, 1);
        wr(2'd1, ctrlb(20, 1));
        rd(2'd1, v); check_eq("R10", "ctrl B locked after nmi", v, ctrlb(7, 0));
        base = total_rd;
        wr(2'd2, 9'b11);
        repeat (5) @(negedge clk);
        check_eq("R10", "start ignored after nmi", total_rd - base, 0);
        check_eq("R10", "nmi stays", nmi, 1);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_pass();
        t_fail_quiet();
        t_lock();
        t_hold_restart(1, "R5");
        t_hold_restart(3, "R5");
        t_hold_restart(2, "R6");
        t_stat_read();
        t_abort();
        t_queue();
        t_cont();
        t_fail_nmi();
        do_reset();
        t_ok_write_nmi();
        done_flag = 1;
        report();
        $finish;
    end
endmodule